// File: doc/BRIEF.md
# Per-Word Coherence State Controller for a Private Cache

This block is the control and state store of a small private first-level cache that tracks coherence per word, not per line. One address tag covers a line of several words. Each word carries its own state: Invalid, Valid or Registered. Each word also stores a region number and a flag that records whether this core touched the word in the current parallel phase. Loads that find an Invalid word fetch it from the shared level. A store takes ownership of its word by sending a registration to the shared level, and the store completes only when the shared level acknowledges that registration.

No invalidation messages arrive from outside. At each phase boundary the core issues a self-invalidate command that names one region. Every Valid word of that region that this core did not touch during the phase drops to Invalid. The command then clears all touched flags. Registered words survive the command. When a line must be replaced, each of its Registered words is written back to the shared level before the new tag is installed. Only one transaction to the shared level is in flight at any time, and core requests stall while it is pending.

Top module: `l1_wordcoh_ctrl`

## Requirements
- R1: After reset every word is Invalid and no tag is valid, so the first read of any address issues a fetch. After reset the core request port is ready, and no response, request or done pulse is active.
- R2: A read of an Invalid word issues one shared-level request of kind 0 (fetch) for that address. It returns the fetched data one cycle after the response is accepted, and the word becomes Valid. A read of a Valid or Registered word answers one cycle after acceptance with no shared-level request.
- R3: A write to an Invalid or Valid word stores the data, makes the word Registered, and issues a request of kind 1 (registration) that carries the address and data. A write to a word that is already Registered updates the data and completes one cycle after acceptance with no request.
- R4: A write that needs registration signals completion on the core response port only in the cycle after the acknowledgement, never earlier.
- R5: A self-invalidate for region r turns every Valid word of region r that was not touched in the phase into Invalid, so its next read fetches again. A done pulse lasting exactly one cycle follows one cycle after the command is accepted.
- R6: Words touched during the phase, and words of other regions, keep their state. All touched flags are cleared by the command, so a later command for the same region invalidates words that went untouched since.
- R7: Registered words are never changed by a self-invalidate.
- R8: Writing one word of a line leaves the state of the other words in that line unchanged.
- R9: A request whose tag misses a line that holds Registered words first writes each of them back with a request of kind 2, lowest word offset first, each after the previous acknowledgement, and only then proceeds. Valid words of the replaced line are dropped without traffic.
- R10: At most one shared-level request is outstanding. Its kind, address and data hold steady until acknowledged, and while it is pending neither the core port nor the self-invalidate port is ready.
- R11: When a self-invalidate command and a core request arrive in the same cycle, the command is taken first and the core request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core presents a load or store |
| core_req_ready | output | 1 | Core request accepted this cycle when valid |
| core_req_write | input | 1 | 1 for store, 0 for load |
| core_req_addr | input | ADDR_W | Word address: tag, line index, word offset |
| core_req_wdata | input | DATA_W | Store data |
| core_req_region | input | REGION_W | Region of the accessed word |
| core_rsp_valid | output | 1 | Load data or store completion |
| core_rsp_rdata | output | DATA_W | Load data (zero for stores) |
| phase_inv_valid | input | 1 | Self-invalidate command |
| phase_inv_ready | output | 1 | Command accepted this cycle when valid |
| phase_inv_region | input | REGION_W | Region to invalidate |
| phase_inv_done | output | 1 | One-cycle pulse after the command is applied |
| mem_req_valid | output | 1 | Request to shared level pending |
| mem_req_kind | output | 2 | 0 fetch, 1 registration, 2 write-back |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_wdata | output | DATA_W | Data for registration or write-back |
| mem_rsp_valid | input | 1 | Acknowledgement, with fetch data for kind 0 |
| mem_rsp_rdata | input | DATA_W | Fetched data |

## Verification
The bench first fills words of two regions. It then runs self-invalidate commands back to back, so that a design which forgets to clear touched flags keeps a word that should drop, and a design which ignores the touched flag drops a word the core just read. A Registered word sits next to a Valid word of the same region. A design that invalidates Registered words, or that lets one word's store change a neighbour, returns a fetch or fresh data where a hit was expected. A replacement of a line with two Registered words checks the order and data of the write-backs. A design that drops them or skips ahead shows a missing or reordered kind 2 request. Throughout, the bench watches for a store completion before the acknowledgement, and for a request that changes while it waits.

// File: rtl/l1wc_pkg.sv
package l1wc_pkg;

  typedef enum logic [1:0] {
    WS_INV = 2'd0,
    WS_VAL = 2'd1,
    WS_REG = 2'd2
  } wstate_e;

  typedef enum logic [1:0] {
    MK_FETCH = 2'd0,
    MK_REGST = 2'd1,
    MK_WBACK = 2'd2
  } mkind_e;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_EVICT = 2'd1,
    C_FILL  = 2'd2,
    C_REG   = 2'd3
  } cstate_e;

endpackage

// File: rtl/l1wc_store.sv
module l1wc_store
  import l1wc_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 8,
  parameter int REGION_W   = 4,
  localparam int IDX_W     = $clog2(LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic [OFF_W-1:0]              rd_off,
  output logic [TAG_W-1:0]              rd_tag,
  output logic                          rd_tag_vld,
  output wstate_e [LINE_WORDS-1:0]      rd_line_st,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [OFF_W-1:0]              wr_off,
  input  logic                          tag_we,
  input  logic [TAG_W-1:0]              tag_val,
  input  logic                          word_we,
  input  logic [DATA_W-1:0]             word_data,
  input  wstate_e                       word_st,
  input  logic [REGION_W-1:0]           word_rgn,
  input  logic                          st_clr_we,
  input  logic                          touch_we,
  input  logic                          inv_en,
  input  logic [REGION_W-1:0]           inv_rgn
);

  logic [TAG_W-1:0]    tag_q  [LINES];
  logic [LINES-1:0]    tvld_q;
  wstate_e             st_q   [LINES][LINE_WORDS];
  logic                tch_q  [LINES][LINE_WORDS];
  logic [REGION_W-1:0] rgn_q  [LINES][LINE_WORDS];
  logic [DATA_W-1:0]   data_q [LINES][LINE_WORDS];

  assign rd_tag     = tag_q[rd_idx];
  assign rd_tag_vld = tvld_q[rd_idx];
  assign rd_data    = data_q[rd_idx][rd_off];

  always_comb begin
    for (int w = 0; w < LINE_WORDS; w++) rd_line_st[w] = st_q[rd_idx][w];
  end

  // state, touched flags and tag-valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvld_q <= '0;
      for (int l = 0; l < LINES; l++) begin
        for (int w = 0; w < LINE_WORDS; w++) begin
          st_q[l][w]  <= WS_INV;
          tch_q[l][w] <= 1'b0;
        end
      end
    end else if (inv_en) begin
      for (int l = 0; l < LINES; l++) begin
        for (int w = 0; w < LINE_WORDS; w++) begin
          if (st_q[l][w] == WS_VAL && rgn_q[l][w] == inv_rgn && !tch_q[l][w])
            st_q[l][w] <= WS_INV;
          tch_q[l][w] <= 1'b0;
        end
      end
    end else begin
      if (tag_we) begin
        tvld_q[wr_idx] <= 1'b1;
        for (int w = 0; w < LINE_WORDS; w++) begin
          st_q[wr_idx][w]  <= WS_INV;
          tch_q[wr_idx][w] <= 1'b0;
        end
      end
      if (st_clr_we) st_q[wr_idx][wr_off] <= WS_INV;
      if (word_we)   st_q[wr_idx][wr_off] <= word_st;
      if (word_we || touch_we) tch_q[wr_idx][wr_off] <= 1'b1;
    end
  end

  // payload arrays carry no reset
  always_ff @(posedge clk) begin
    if (tag_we) tag_q[wr_idx] <= tag_val;
    if (word_we) begin
      data_q[wr_idx][wr_off] <= word_data;
      rgn_q[wr_idx][wr_off]  <= word_rgn;
    end
  end

endmodule

// File: rtl/l1wc_reg_pick.sv
module l1wc_reg_pick
  import l1wc_pkg::*;
#(
  parameter int N  = 4,
  localparam int W = $clog2(N)
) (
  input  wstate_e [N-1:0] st,
  output logic            found,
  output logic            more,
  output logic [W-1:0]    first
);

  logic [N-1:0] is_reg;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign is_reg[g] = (st[g] == WS_REG);
  end

  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (is_reg[i]) first = W'(i);
    end
  end

  assign found = |is_reg;
  assign more  = ($countones(is_reg) > 1);

endmodule

// File: rtl/l1_wordcoh_ctrl.sv
module l1_wordcoh_ctrl
  import l1wc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 4,
  parameter int REGION_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_req_valid,
  output logic                core_req_ready,
  input  logic                core_req_write,
  input  logic [ADDR_W-1:0]   core_req_addr,
  input  logic [DATA_W-1:0]   core_req_wdata,
  input  logic [REGION_W-1:0] core_req_region,
  output logic                core_rsp_valid,
  output logic [DATA_W-1:0]   core_rsp_rdata,
  input  logic                phase_inv_valid,
  output logic                phase_inv_ready,
  input  logic [REGION_W-1:0] phase_inv_region,
  output logic                phase_inv_done,
  output logic                mem_req_valid,
  output logic [1:0]          mem_req_kind,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_rdata
);

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  cstate_e state_q, state_d;

  logic                q_write;
  logic [ADDR_W-1:0]   q_addr;
  logic [DATA_W-1:0]   q_wdata;
  logic [REGION_W-1:0] q_region;
  logic                cap;

  logic                rsp_valid_q, rsp_set;
  logic [DATA_W-1:0]   rsp_data_q, rsp_d;
  logic                inv_done_q;

  logic [ADDR_W-1:0]   look_addr;
  logic [OFF_W-1:0]    look_off, rd_off, wr_off;
  logic [IDX_W-1:0]    look_idx;
  logic [TAG_W-1:0]    look_tag;

  logic [TAG_W-1:0]          rd_tag;
  logic                      rd_tag_vld;
  wstate_e [LINE_WORDS-1:0]  rd_line_st;
  logic [DATA_W-1:0]         rd_data;
  wstate_e                   cur_st;
  logic                      tag_hit;

  logic                tag_we, word_we, st_clr_we, touch_we, inv_en;
  wstate_e             word_st;
  logic [DATA_W-1:0]   w_data;
  logic [REGION_W-1:0] w_rgn;

  logic                pick_found, pick_more;
  logic [OFF_W-1:0]    pick_off;

  // address decode: live request while idle, held request otherwise
  assign look_addr = (state_q == C_IDLE) ? core_req_addr : q_addr;
  assign look_off  = look_addr[OFF_W-1:0];
  assign look_idx  = look_addr[OFF_W +: IDX_W];
  assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
  assign rd_off    = (state_q == C_EVICT) ? pick_off : look_off;

  l1wc_store #(
    .LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
    .TAG_W(TAG_W), .REGION_W(REGION_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_off(rd_off),
    .rd_tag(rd_tag), .rd_tag_vld(rd_tag_vld), .rd_line_st(rd_line_st), .rd_data(rd_data),
    .wr_idx(look_idx), .wr_off(wr_off),
    .tag_we(tag_we), .tag_val(look_tag),
    .word_we(word_we), .word_data(w_data), .word_st(word_st), .word_rgn(w_rgn),
    .st_clr_we(st_clr_we), .touch_we(touch_we),
    .inv_en(inv_en), .inv_rgn(phase_inv_region)
  );

  l1wc_reg_pick #(.N(LINE_WORDS)) u_pick (
    .st(rd_line_st), .found(pick_found), .more(pick_more), .first(pick_off)
  );

  assign cur_st  = rd_line_st[look_off];
  assign tag_hit = rd_tag_vld && (rd_tag == look_tag);

  assign core_req_ready  = (state_q == C_IDLE) && !phase_inv_valid;
  assign phase_inv_ready = (state_q == C_IDLE);

  // next-state and control
  always_comb begin
    state_d   = state_q;
    cap       = 1'b0;
    tag_we    = 1'b0;
    word_we   = 1'b0;
    word_st   = WS_VAL;
    w_data    = '0;
    w_rgn     = '0;
    st_clr_we = 1'b0;
    touch_we  = 1'b0;
    inv_en    = 1'b0;
    rsp_set   = 1'b0;
    rsp_d     = '0;
    wr_off    = look_off;
    unique case (state_q)
      C_IDLE: begin
        if (phase_inv_valid) begin
          inv_en = 1'b1;
        end else if (core_req_valid) begin
          cap = 1'b1;
          if (!tag_hit) begin
            if (rd_tag_vld && pick_found) begin
              state_d = C_EVICT;
            end else begin
              tag_we = 1'b1;
              if (core_req_write) begin
                word_we = 1'b1;
                word_st = WS_REG;
                w_data  = core_req_wdata;
                w_rgn   = core_req_region;
                state_d = C_REG;
              end else begin
                state_d = C_FILL;
              end
            end
          end else if (!core_req_write) begin
            if (cur_st != WS_INV) begin
              touch_we = 1'b1;
              rsp_set  = 1'b1;
              rsp_d    = rd_data;
            end else begin
              state_d = C_FILL;
            end
          end else begin
            word_we = 1'b1;
            word_st = WS_REG;
            w_data  = core_req_wdata;
            w_rgn   = core_req_region;
            if (cur_st == WS_REG) rsp_set = 1'b1;
            else                  state_d = C_REG;
          end
        end
      end
      C_EVICT: begin
        if (mem_rsp_valid) begin
          if (pick_more) begin
            st_clr_we = 1'b1;
            wr_off    = pick_off;
          end else begin
            tag_we = 1'b1;
            if (q_write) begin
              word_we = 1'b1;
              word_st = WS_REG;
              w_data  = q_wdata;
              w_rgn   = q_region;
              state_d = C_REG;
            end else begin
              state_d = C_FILL;
            end
          end
        end
      end
      C_FILL: begin
        if (mem_rsp_valid) begin
          word_we = 1'b1;
          word_st = WS_VAL;
          w_data  = mem_rsp_rdata;
          w_rgn   = q_region;
          rsp_set = 1'b1;
          rsp_d   = mem_rsp_rdata;
          state_d = C_IDLE;
        end
      end
      C_REG: begin
        if (mem_rsp_valid) begin
          rsp_set = 1'b1;
          state_d = C_IDLE;
        end
      end
      default: state_d = C_IDLE;
    endcase
  end

  // shared-level request, a function of held state only
  always_comb begin
    mem_req_valid = (state_q != C_IDLE);
    mem_req_kind  = MK_FETCH;
    mem_req_addr  = q_addr;
    mem_req_wdata = '0;
    unique case (state_q)
      C_EVICT: begin
        mem_req_kind  = MK_WBACK;
        mem_req_addr  = {rd_tag, look_idx, pick_off};
        mem_req_wdata = rd_data;
      end
      C_REG: begin
        mem_req_kind  = MK_REGST;
        mem_req_wdata = q_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= C_IDLE;
      rsp_valid_q <= 1'b0;
      inv_done_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_set;
      inv_done_q  <= inv_en;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      q_write  <= core_req_write;
      q_addr   <= core_req_addr;
      q_wdata  <= core_req_wdata;
      q_region <= core_req_region;
    end
    if (rsp_set) rsp_data_q <= rsp_d;
  end

  assign core_rsp_valid = rsp_valid_q;
  assign core_rsp_rdata = rsp_data_q;
  assign phase_inv_done = inv_done_q;

endmodule

// File: rtl/l1_wordcoh_chk.sv
module l1_wordcoh_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req_ready,
  input logic              core_rsp_valid,
  input logic [DATA_W-1:0] core_rsp_rdata,
  input logic              phase_inv_valid,
  input logic              phase_inv_ready,
  input logic              phase_inv_done,
  input logic              mem_req_valid,
  input logic [1:0]        mem_req_kind,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_rdata
);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_kind)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  a_r10_ports_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !core_req_ready && !phase_inv_ready);

  a_r4_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_kind == 2'd1 && !mem_rsp_valid |=> !core_rsp_valid);

  a_r2_fill_returned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_kind == 2'd0 && mem_rsp_valid
      |=> core_rsp_valid && core_rsp_rdata == $past(mem_rsp_rdata));

  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    phase_inv_valid && phase_inv_ready |=> phase_inv_done);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    phase_inv_done |=> !phase_inv_done || $past(phase_inv_valid && phase_inv_ready));

  a_r9_wb_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_kind == 2'd2 |=> !core_rsp_valid);

endmodule

bind l1_wordcoh_ctrl l1_wordcoh_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req_ready(core_req_ready),
  .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
  .phase_inv_valid(phase_inv_valid), .phase_inv_ready(phase_inv_ready),
  .phase_inv_done(phase_inv_done), .mem_req_valid(mem_req_valid),
  .mem_req_kind(mem_req_kind), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_rdata(mem_rsp_rdata)
);

// File: tb/l1_wordcoh_ctrl_tb_top.sv
module l1_wordcoh_ctrl_tb_top;

  localparam int DW = 32;
  localparam int AW = 12;
  localparam int RW = 4;

  logic          clk, rst_n;
  logic          core_req_valid, core_req_ready, core_req_write;
  logic [AW-1:0] core_req_addr;
  logic [DW-1:0] core_req_wdata;
  logic [RW-1:0] core_req_region;
  logic          core_rsp_valid;
  logic [DW-1:0] core_rsp_rdata;
  logic          phase_inv_valid, phase_inv_ready, phase_inv_done;
  logic [RW-1:0] phase_inv_region;
  logic          mem_req_valid;
  logic [1:0]    mem_req_kind;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  l1_wordcoh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_write(core_req_write), .core_req_addr(core_req_addr),
    .core_req_wdata(core_req_wdata), .core_req_region(core_req_region),
    .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
    .phase_inv_valid(phase_inv_valid), .phase_inv_ready(phase_inv_ready),
    .phase_inv_region(phase_inv_region), .phase_inv_done(phase_inv_done),
    .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { logic [1:0] kind; logic [AW-1:0] addr; logic [DW-1:0] data; string req; } mexp_t;
  typedef struct { logic [DW-1:0] data; string req; } rexp_t;
  mexp_t mq[$];
  rexp_t rq[$];

  int n_chk = 0;
  int n_err = 0;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return 32'hA000_0000 | {20'd0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_mem(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    mexp_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = req;
    mq.push_back(e);
  endtask

  task automatic exp_rsp(input logic [DW-1:0] d, input string req);
    rexp_t e;
    e.data = d; e.req = req;
    rq.push_back(e);
  endtask

  // shared-level model and request checker
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [1:0]    k;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        k = mem_req_kind; a = mem_req_addr; d = mem_req_wdata;
        if (mq.size() == 0) begin
          chk(1'b0, "R10 unexpected request", {18'd0, k, a}, '0);
        end else begin
          mexp_t e;
          e = mq.pop_front();
          chk(k == e.kind, {e.req, " kind"}, {30'd0, k}, {30'd0, e.kind});
          chk(a == e.addr, {e.req, " addr"}, {20'd0, a}, {20'd0, e.addr});
          if (k != 2'd0) chk(d == e.data, {e.req, " data"}, d, e.data);
        end
        chk(!core_req_ready && !phase_inv_ready, "R10 ports stall", {31'd0, core_req_ready}, '0);
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a && mem_req_kind == k, "R10 request held",
              {20'd0, mem_req_addr}, {20'd0, a});
          if (k == 2'd1) chk(!core_rsp_valid, "R4 no completion before ack", {31'd0, core_rsp_valid}, '0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = (k == 2'd0) ? mem_val(a) : '0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // core response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && core_rsp_valid) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R2 unexpected response", core_rsp_rdata, '0);
        end else begin
          rexp_t e;
          e = rq.pop_front();
          chk(core_rsp_rdata == e.data, e.req, core_rsp_rdata, e.data);
        end
      end
    end
  end

  task automatic drive_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [RW-1:0] r);
    core_req_valid  = 1'b1;
    core_req_write  = w;
    core_req_addr   = a;
    core_req_wdata  = d;
    core_req_region = r;
  endtask

  task automatic wait_accept();
    #1;
    while (!core_req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 core_req_valid = 1'b0;
  endtask

  task automatic settle();
    while (rq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [RW-1:0] r);
    @(negedge clk);
    drive_req(w, a, d, r);
    wait_accept();
    settle();
  endtask

  // a hit must answer at the first negedge after acceptance
  task automatic access_hit(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [RW-1:0] r, input string req);
    @(negedge clk);
    drive_req(w, a, d, r);
    wait_accept();
    @(negedge clk);
    chk(core_rsp_valid, req, {31'd0, core_rsp_valid}, 32'd1);
    settle();
  endtask

  task automatic self_inv(input logic [RW-1:0] r);
    @(negedge clk);
    phase_inv_valid  = 1'b1;
    phase_inv_region = r;
    #1 chk(phase_inv_ready, "R5 command accepted when idle", {31'd0, phase_inv_ready}, 32'd1);
    @(posedge clk);
    #1 phase_inv_valid = 1'b0;
    @(negedge clk);
    chk(phase_inv_done, "R5 done pulse", {31'd0, phase_inv_done}, 32'd1);
    @(negedge clk);
    chk(!phase_inv_done, "R5 done one cycle", {31'd0, phase_inv_done}, 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    core_req_valid = 1'b0; core_req_write = 1'b0; core_req_addr = '0;
    core_req_wdata = '0; core_req_region = '0;
    phase_inv_valid = 1'b0; phase_inv_region = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_req_ready, "R1 ready after reset", {31'd0, core_req_ready}, 32'd1);
    chk(!mem_req_valid && !core_rsp_valid && !phase_inv_done, "R1 quiet after reset",
        {29'd0, mem_req_valid, core_rsp_valid, phase_inv_done}, '0);

    // R1/R2 first read fetches, second hits
    exp_mem(2'd0, 12'h010, '0, "R1 fetch after reset");
    exp_rsp(mem_val(12'h010), "R2 fetched data");
    access(1'b0, 12'h010, '0, 4'd1);
    exp_rsp(mem_val(12'h010), "R2 hit data");
    access_hit(1'b0, 12'h010, '0, 4'd1, "R2 hit latency");

    // R3 registration, R8 neighbour untouched
    exp_mem(2'd1, 12'h011, 32'h0000_1111, "R3 registration");
    exp_rsp('0, "R4 store completion");
    access(1'b1, 12'h011, 32'h0000_1111, 4'd1);
    exp_rsp(32'h0000_1111, "R3 registered data");
    access_hit(1'b0, 12'h011, '0, 4'd1, "R3 registered hit");
    exp_rsp(mem_val(12'h010), "R8 neighbour still valid");
    access_hit(1'b0, 12'h010, '0, 4'd1, "R8 neighbour hit");
    exp_rsp('0, "R3 store to registered word");
    access_hit(1'b1, 12'h011, 32'h0000_2222, 4'd1, "R3 no registration needed");
    exp_rsp(32'h0000_2222, "R3 updated data");
    access_hit(1'b0, 12'h011, '0, 4'd1, "R3 updated hit");

    // R5/R6 self-invalidate behaviour
    exp_mem(2'd0, 12'h024, '0, "R2 fetch region 2");
    exp_rsp(mem_val(12'h024), "R2 region 2 data");
    access(1'b0, 12'h024, '0, 4'd2);
    exp_mem(2'd0, 12'h025, '0, "R2 fetch region 3");
    exp_rsp(mem_val(12'h025), "R2 region 3 data");
    access(1'b0, 12'h025, '0, 4'd3);
    self_inv(4'd2);
    exp_rsp(mem_val(12'h024), "R6 touched word kept");
    access_hit(1'b0, 12'h024, '0, 4'd2, "R6 touched word hit");
    self_inv(4'd2);
    self_inv(4'd2);
    exp_mem(2'd0, 12'h024, '0, "R5 untouched word refetched");
    exp_rsp(mem_val(12'h024), "R5 refetch data");
    access(1'b0, 12'h024, '0, 4'd2);
    exp_rsp(mem_val(12'h025), "R6 other region kept");
    access_hit(1'b0, 12'h025, '0, 4'd3, "R6 other region hit");
    self_inv(4'd1);
    exp_rsp(32'h0000_2222, "R7 registered word kept");
    access_hit(1'b0, 12'h011, '0, 4'd1, "R7 registered hit");
    exp_mem(2'd0, 12'h010, '0, "R5 valid region 1 word refetched");
    exp_rsp(mem_val(12'h010), "R5 refetch data");
    access(1'b0, 12'h010, '0, 4'd1);

    // R11 command before a simultaneous core request
    self_inv(4'd0);
    exp_mem(2'd0, 12'h025, '0, "R11 command applied first");
    exp_rsp(mem_val(12'h025), "R11 refetch data");
    @(negedge clk);
    phase_inv_valid  = 1'b1;
    phase_inv_region = 4'd3;
    drive_req(1'b0, 12'h025, '0, 4'd3);
    #1 chk(!core_req_ready, "R11 core request waits", {31'd0, core_req_ready}, '0);
    @(posedge clk);
    #1 phase_inv_valid = 1'b0;
    @(negedge clk);
    wait_accept();
    settle();

    // R9 replacement with two registered words
    exp_mem(2'd1, 12'h013, 32'h0000_3333, "R3 second registration");
    exp_rsp('0, "R4 store completion");
    access(1'b1, 12'h013, 32'h0000_3333, 4'd1);
    exp_mem(2'd2, 12'h011, 32'h0000_2222, "R9 first write-back");
    exp_mem(2'd2, 12'h013, 32'h0000_3333, "R9 second write-back");
    exp_mem(2'd0, 12'h050, '0, "R9 fetch after write-backs");
    exp_rsp(mem_val(12'h050), "R9 new line data");
    access(1'b0, 12'h050, '0, 4'd1);
    exp_mem(2'd0, 12'h011, '0, "R9 valid line dropped silently");
    exp_rsp(mem_val(12'h011), "R9 refetch data");
    access(1'b0, 12'h011, '0, 4'd1);
    exp_mem(2'd1, 12'h0A1, 32'h0000_4444, "R9 store on tag miss");
    exp_rsp('0, "R4 store completion");
    access(1'b1, 12'h0A1, 32'h0000_4444, 4'd1);
    exp_rsp(32'h0000_4444, "R9 installed store data");
    access_hit(1'b0, 12'h0A1, '0, 4'd1, "R9 installed store hit");

    repeat (4) @(negedge clk);
    chk(mq.size() == 0, "R9 all expected requests seen", mq.size(), '0);
    chk(rq.size() == 0, "R2 all expected responses seen", rq.size(), '0);
    finish_run();
  end

endmodule